// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sequences the low-power states of a small 8-bit microcontroller core. Software writes a two-bit mode field: one bit requests a light sleep (Idle) and the other a deep sleep (Stop). The request takes effect only when the CPU signals that the writing instruction has completed. In Idle the CPU clock is gated, while peripheral clocks and the internal oscillator keep running. In Stop the CPU clock, the peripheral clocks and the internal oscillator enable are all turned off.

The two sleep states have different wake rules. Idle ends on any enabled pending interrupt. The Idle bit then clears itself in hardware, and the CPU resumes to service the interrupt. Stop ignores interrupts and ends only through a reset request. Three reset sources can end it: an external reset, a watchdog time-out, or the missing-clock detector (the guaranteed exit, since clocks are gone). Any of these requests, in any state, drives a core reset pulse of fixed length that sends the core to its reset vector. The same request clears the mode field and records a reset-cause code. A one-cycle wake pulse marks every exit from a sleep state.

All ports are plain control and status signals. The block has no streaming interface, so it has no valid/ready handshake.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset (rst_n low), the mode field reads 0. The CPU clock, peripheral clock and oscillator enables are all 1, and core_rst and wake_pulse are 0. rst_cause reads 0, the power-on code.
- R2: Writing a mode bit (bit 0 = Idle, bit 1 = Stop) does not enter a sleep state while insn_done is low. The bit reads back as set, and the CPU clock enable stays 1.
- R3: Entry happens on the first clock edge where insn_done is high and a mode bit is set, either in the register or in the same cycle's write. For Idle, cpu_clk_en goes to 0 one cycle after that edge, while periph_clk_en and int_osc_en stay 1.
- R4: In Stop, cpu_clk_en, periph_clk_en and int_osc_en are all 0.
- R5: When both mode bits are set at entry, Stop is entered, not Idle.
- R6: In Idle, a high irq_pending returns the block to run at the next edge. cpu_clk_en becomes 1, the Idle bit reads 0, and wake_pulse is high for exactly one cycle.
- R7: In Stop, irq_pending has no effect. The clock enables stay 0, the mode field stays set, and wake_pulse stays 0.
- R8: A reset request (ext_rst_req, wdt_rst_req or mcd_rst_req) sampled at an edge makes core_rst high for exactly RST_CYCLES cycles after that edge. At the same edge it clears both mode bits and returns the block to run.
- R9: rst_cause records the last reset request: 1 = external, 2 = watchdog, 3 = missing clock. When requests coincide, the priority is external, then missing clock, then watchdog. The code holds until the next request or power-on reset.
- R10: A reset request that ends Idle or Stop raises wake_pulse for one cycle. A reset request taken while running does not.
- R11: While core_rst is high, mode writes and insn_done are ignored. The mode field stays 0 and cpu_clk_en stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (free-running) |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| mode_wr_en | input | 1 | Write strobe for the mode field |
| mode_wr_data | input | 2 | Write data: bit 0 Idle request, bit 1 Stop request |
| mode_rd_data | output | 2 | Current mode field |
| insn_done | input | 1 | CPU strobe: the current instruction has completed |
| irq_pending | input | 1 | An enabled interrupt is pending |
| ext_rst_req | input | 1 | External reset request |
| wdt_rst_req | input | 1 | Watchdog reset request |
| mcd_rst_req | input | 1 | Missing-clock detector reset request |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| int_osc_en | output | 1 | Internal oscillator enable |
| core_rst | output | 1 | Reset to the core, sends it to the reset vector |
| wake_pulse | output | 1 | One-cycle pulse on leaving Idle or Stop |
| rst_cause | output | 2 | Code of the last reset request |

## Verification
The assertions assume that every input is synchronous to clk and stable around its rising edge. They also assume that reset requests are level signals sampled on each edge, and that the mode write strobe comes from the CPU while it is running. The stimulus changes every input one time unit after a rising edge and holds each reset request for a single cycle, so every pulse length can be counted from a known edge. While the core is halted, the stimulus also drives writes and insn_done to check that they are ignored. It raises interrupts during Stop to check that they have no effect.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_STOP = 2'd2
  } pm_state_e;

  typedef enum logic [1:0] {
    RC_POWERON = 2'd0,
    RC_EXT     = 2'd1,
    RC_WDOG    = 2'd2,
    RC_CLKLOSS = 2'd3
  } rst_cause_e;

  localparam int unsigned MODE_W   = 2;
  localparam int unsigned IDLE_POS = 0;
  localparam int unsigned STOP_POS = 1;
endpackage

// File: rtl/pmc_mode_reg.sv
module pmc_mode_reg
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  input  logic              block_wr,
  input  logic              clr_idle,
  input  logic              clr_all,
  output logic [MODE_W-1:0] mode_q,
  output logic [MODE_W-1:0] mode_eff
);
  logic wr_ok;
  assign wr_ok    = wr_en && !block_wr;
  assign mode_eff = wr_ok ? wr_data : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (clr_all) begin
      mode_q <= '0;
    end else if (clr_idle) begin
      mode_q[IDLE_POS] <= 1'b0;
    end else if (wr_ok) begin
      mode_q <= wr_data;
    end
  end

  p_clear_on_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (mode_q == '0));
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_eff,
  input  logic              insn_done,
  input  logic              irq_pending,
  input  logic              rst_any,
  input  logic              hold,
  output pm_state_e         state_q,
  output logic              clr_idle,
  output logic              wake_q
);
  pm_state_e state_d;
  logic      wake_d;

  assign clr_idle = (state_q == PM_IDLE) && irq_pending && !rst_any;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    if (rst_any) begin
      state_d = PM_RUN;
      wake_d  = (state_q != PM_RUN);
    end else begin
      unique case (state_q)
        PM_RUN: begin
          if (!hold && insn_done) begin
            if (mode_eff[STOP_POS])      state_d = PM_STOP;
            else if (mode_eff[IDLE_POS]) state_d = PM_IDLE;
          end
        end
        PM_IDLE: begin
          if (irq_pending) begin
            state_d = PM_RUN;
            wake_d  = 1'b1;
          end
        end
        PM_STOP: state_d = PM_STOP;
        default: state_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  p_entry_waits_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN && !insn_done) |=> (state_q == PM_RUN));
  p_stop_ignores_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_STOP && !rst_any) |=> (state_q == PM_STOP && !wake_q));
  p_wake_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);
  p_stop_priority_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN && !hold && !rst_any && insn_done && mode_eff[STOP_POS])
      |=> (state_q == PM_STOP));
endmodule

// File: rtl/pmc_rst_gen.sv
module pmc_rst_gen
  import pmc_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_req,
  input  logic       wdt_req,
  input  logic       mcd_req,
  output logic       rst_any,
  output logic       core_rst,
  output rst_cause_e cause_q
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

  logic [CW-1:0] cnt_q;
  rst_cause_e    cause_d;

  assign rst_any  = ext_req || wdt_req || mcd_req;
  assign core_rst = (cnt_q != '0);

  always_comb begin
    if (ext_req)      cause_d = RC_EXT;
    else if (mcd_req) cause_d = RC_CLKLOSS;
    else              cause_d = RC_WDOG;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cause_q <= RC_POWERON;
    end else if (rst_any) begin
      cnt_q   <= LOAD;
      cause_q <= cause_d;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_req_starts_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_any |=> core_rst);
  p_cause_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_any |=> $stable(cause_q));
  p_ext_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |=> (cause_q == RC_EXT));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr_en,
  input  logic [MODE_W-1:0] mode_wr_data,
  output logic [MODE_W-1:0] mode_rd_data,
  input  logic              insn_done,
  input  logic              irq_pending,
  input  logic              ext_rst_req,
  input  logic              wdt_rst_req,
  input  logic              mcd_rst_req,
  output logic              cpu_clk_en,
  output logic              periph_clk_en,
  output logic              int_osc_en,
  output logic              core_rst,
  output logic              wake_pulse,
  output logic [1:0]        rst_cause
);
  pm_state_e         state_q;
  rst_cause_e        cause_q;
  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] mode_eff;
  logic              rst_any;
  logic              clr_idle;
  logic              halted;

  assign halted = (state_q != PM_RUN);

  pmc_rst_gen #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_req  (ext_rst_req),
    .wdt_req  (wdt_rst_req),
    .mcd_req  (mcd_rst_req),
    .rst_any  (rst_any),
    .core_rst (core_rst),
    .cause_q  (cause_q)
  );

  pmc_mode_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (mode_wr_en),
    .wr_data  (mode_wr_data),
    .block_wr (core_rst || halted),
    .clr_idle (clr_idle),
    .clr_all  (rst_any),
    .mode_q   (mode_q),
    .mode_eff (mode_eff)
  );

  pmc_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_eff    (mode_eff),
    .insn_done   (insn_done),
    .irq_pending (irq_pending),
    .rst_any     (rst_any),
    .hold        (core_rst),
    .state_q     (state_q),
    .clr_idle    (clr_idle),
    .wake_q      (wake_pulse)
  );

  assign mode_rd_data  = mode_q;
  assign cpu_clk_en    = (state_q == PM_RUN);
  assign periph_clk_en = (state_q != PM_STOP);
  assign int_osc_en    = (state_q != PM_STOP);
  assign rst_cause     = cause_q;

  p_idle_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_IDLE && irq_pending && !rst_any)
      |=> (cpu_clk_en && !mode_rd_data[IDLE_POS] && wake_pulse));
  p_field_zero_in_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (mode_rd_data == '0 && cpu_clk_en));
  p_stop_keeps_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_STOP && !rst_any) |=> $stable(mode_rd_data));
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int RSTC = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_wr_en;
  logic [1:0] mode_wr_data;
  logic [1:0] mode_rd_data;
  logic       insn_done, irq_pending;
  logic       ext_rst_req, wdt_rst_req, mcd_rst_req;
  logic       cpu_clk_en, periph_clk_en, int_osc_en;
  logic       core_rst, wake_pulse;
  logic [1:0] rst_cause;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.RST_CYCLES(RSTC)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data), .mode_rd_data(mode_rd_data),
    .insn_done(insn_done), .irq_pending(irq_pending),
    .ext_rst_req(ext_rst_req), .wdt_rst_req(wdt_rst_req), .mcd_rst_req(mcd_rst_req),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .int_osc_en(int_osc_en),
    .core_rst(core_rst), .wake_pulse(wake_pulse), .rst_cause(rst_cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic write_mode(input logic [1:0] d, input logic fin);
    mode_wr_en = 1'b1; mode_wr_data = d; insn_done = fin;
    step();
    mode_wr_en = 1'b0; mode_wr_data = 2'b00; insn_done = 1'b0;
  endtask

  task automatic pulse_rst(input logic e, input logic w, input logic m);
    ext_rst_req = e; wdt_rst_req = w; mcd_rst_req = m;
    step();
    ext_rst_req = 1'b0; wdt_rst_req = 1'b0; mcd_rst_req = 1'b0;
  endtask

  task automatic finish_rst(input string req);
    for (int i = 1; i < RSTC; i++) begin
      chk(req, core_rst, 1);
      step();
    end
    chk(req, core_rst, 1);
    step();
    chk(req, core_rst, 0);
  endtask

  task automatic t_reset_state();
    chk("R1 field", mode_rd_data, 0);
    chk("R1 cpu", cpu_clk_en, 1);
    chk("R1 periph", periph_clk_en, 1);
    chk("R1 osc", int_osc_en, 1);
    chk("R1 core_rst", core_rst, 0);
    chk("R1 wake", wake_pulse, 0);
    chk("R1 cause", rst_cause, 0);
  endtask

  task automatic t_entry_waits();
    write_mode(2'b01, 1'b0);
    chk("R2 readback", mode_rd_data, 1);
    chk("R2 cpu", cpu_clk_en, 1);
    step(); step(); step();
    chk("R2 cpu later", cpu_clk_en, 1);
    insn_done = 1'b1;
    step();
    insn_done = 1'b0;
    chk("R3 cpu", cpu_clk_en, 0);
    chk("R3 periph", periph_clk_en, 1);
    chk("R3 osc", int_osc_en, 1);
  endtask

  task automatic t_idle_irq();
    irq_pending = 1'b1;
    step();
    irq_pending = 1'b0;
    chk("R6 cpu", cpu_clk_en, 1);
    chk("R6 idle bit", mode_rd_data, 0);
    chk("R6 wake", wake_pulse, 1);
    step();
    chk("R6 wake once", wake_pulse, 0);
    chk("R6 cpu stays", cpu_clk_en, 1);
  endtask

  task automatic t_stop_irq_mcd();
    write_mode(2'b10, 1'b1);
    chk("R4 cpu", cpu_clk_en, 0);
    chk("R4 periph", periph_clk_en, 0);
    chk("R4 osc", int_osc_en, 0);
    irq_pending = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R7 cpu", cpu_clk_en, 0);
      chk("R7 wake", wake_pulse, 0);
    end
    irq_pending = 1'b0;
    chk("R7 field", mode_rd_data, 2);
    pulse_rst(1'b0, 1'b0, 1'b1);
    chk("R10 wake", wake_pulse, 1);
    chk("R9 cause clkloss", rst_cause, 3);
    chk("R8 field", mode_rd_data, 0);
    chk("R8 cpu", cpu_clk_en, 1);
    chk("R8 periph", periph_clk_en, 1);
    finish_rst("R8 length");
  endtask

  task automatic t_both_bits();
    write_mode(2'b11, 1'b1);
    chk("R5 periph", periph_clk_en, 0);
    chk("R5 osc", int_osc_en, 0);
    pulse_rst(1'b1, 1'b0, 1'b0);
    chk("R9 cause ext", rst_cause, 1);
    chk("R10 wake stop", wake_pulse, 1);
    finish_rst("R8 ext length");
  endtask

  task automatic t_wdt_idle();
    write_mode(2'b01, 1'b1);
    chk("R3 idle again", cpu_clk_en, 0);
    pulse_rst(1'b0, 1'b1, 1'b0);
    chk("R9 cause wdog", rst_cause, 2);
    chk("R10 wake idle", wake_pulse, 1);
    chk("R8 idle field", mode_rd_data, 0);
    finish_rst("R8 wdog length");
  endtask

  task automatic t_run_reset();
    pulse_rst(1'b1, 1'b0, 1'b0);
    chk("R10 no wake from run", wake_pulse, 0);
    chk("R9 cause ext run", rst_cause, 1);
    finish_rst("R8 run length");
    step();
    chk("R9 cause held", rst_cause, 1);
  endtask

  task automatic t_priority();
    pulse_rst(1'b1, 1'b1, 1'b1);
    chk("R9 all three", rst_cause, 1);
    finish_rst("R8 prio");
    pulse_rst(1'b0, 1'b1, 1'b1);
    chk("R9 mcd over wdog", rst_cause, 3);
    finish_rst("R8 prio2");
  endtask

  task automatic t_write_blocked();
    pulse_rst(1'b0, 1'b1, 1'b0);
    write_mode(2'b01, 1'b1);
    chk("R11 field", mode_rd_data, 0);
    chk("R11 cpu", cpu_clk_en, 1);
    write_mode(2'b10, 1'b1);
    chk("R11 field stop", mode_rd_data, 0);
    chk("R11 periph", periph_clk_en, 1);
    step(); step(); step();
    chk("R11 after", core_rst, 0);
    chk("R11 cpu after", cpu_clk_en, 1);
    chk("R11 field after", mode_rd_data, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    mode_wr_en = 1'b0; mode_wr_data = 2'b00; insn_done = 1'b0; irq_pending = 1'b0;
    ext_rst_req = 1'b0; wdt_rst_req = 1'b0; mcd_rst_req = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset_state();
    t_entry_waits();
    t_idle_irq();
    t_stop_irq_mcd();
    t_both_bits();
    t_wdt_idle();
    t_run_reset();
    t_priority();
    t_write_blocked();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule